// File: doc/BRIEF.md
# Function Error Signalling Gate

This block sits beside one endpoint function. It takes each detected error and works out two things: which status bits the error sets, and whether an error message goes out. It also decides whether the error's header information is logged. Each error arrives as a one-cycle strobe. The strobe carries a status vector, a class flag (correctable or uncorrectable), an advisory-capable flag and an unsupported-request flag.

The block reads the function's live configuration: the reporting enables, the system-error enable, the correctable mask, the uncorrectable mask and the uncorrectable severity register. From these it produces three sets of set-pulses, one each for the device status register, the correctable status register and the uncorrectable status register. It also produces a log request and a message strobe with a two-bit severity code. The registers themselves live outside the block. Forwarding a message past the function is left to other logic.

Top module: `errgate_top`

## Requirements
- R1: All outputs are registered and valid in the cycle after `errValid`; with no accepted error in the previous cycle every output is zero. `devStaSet` bit 0 marks correctable-detected, bit 1 non-fatal-detected, bit 2 fatal-detected and bit 3 unsupported-request-detected; `msgSev` is 0 for correctable, 1 for non-fatal and 2 for fatal.
- R2: The status vector is first masked with the supported set for its class (`COR_SUP` or `UNC_SUP`). If the result has zero bits or more than one bit set, the error is dropped and every output stays zero.
- R3: An accepted correctable error sets correctable-detected and its own bit in `corStaSet`; with `errIsUr` it also sets unsupported-request-detected. It never raises `logReq`.
- R4: A correctable-class message (severity 0) is sent only when the reported correctable bit is clear in `corMask` and `corRptEn` is set; with `errIsUr` it also needs `urRptEn`.
- R5: For an uncorrectable error, the `uncSeverity` bit at the error's position selects the class: 1 means fatal, 0 means non-fatal.
- R6: A non-fatal uncorrectable error with `errMayAdvisory` is reported as correctable. It sets correctable-detected (plus unsupported-request-detected if flagged), sets bit `ADV_BIT` of `corStaSet` and still sets its bit in `uncStaSet`. It is messaged under the R4 rules, using `corMask[ADV_BIT]`. A fatal error ignores the advisory flag.
- R7: An advisory error raises `logReq` only when `corMask[ADV_BIT]` is clear and its uncorrectable bit is clear in `uncMask`.
- R8: A masked uncorrectable error still sets its `uncStaSet` bit and the fatal- or non-fatal-detected bit (plus unsupported-request-detected if flagged). It raises neither `logReq` nor a message.
- R9: An unmasked, non-advisory uncorrectable error raises `logReq`, sets its `uncStaSet` bit and sets fatal-detected or non-fatal-detected according to R5.
- R10: A fatal message (severity 2) needs `serrEn` or `fatRptEn`, and a non-fatal message (severity 1) needs `serrEn` or `nfRptEn`. An unsupported request with neither `urRptEn` nor `serrEn` sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | One-cycle detected-error strobe |
| errStatus | input | max(COR_W,UNC_W) | Status bit of the error, one-hot expected |
| errIsCor | input | 1 | 1 = correctable class, 0 = uncorrectable |
| errMayAdvisory | input | 1 | Error may be reported as advisory if non-fatal |
| errIsUr | input | 1 | Error is an unsupported request |
| corRptEn | input | 1 | Correctable reporting enable |
| nfRptEn | input | 1 | Non-fatal reporting enable |
| fatRptEn | input | 1 | Fatal reporting enable |
| urRptEn | input | 1 | Unsupported-request reporting enable |
| serrEn | input | 1 | System-error enable from the command register |
| corMask | input | COR_W | Correctable error mask |
| uncMask | input | UNC_W | Uncorrectable error mask |
| uncSeverity | input | UNC_W | Uncorrectable severity, 1 = fatal |
| devStaSet | output | 4 | Device status set pulses |
| corStaSet | output | COR_W | Correctable status set pulses |
| uncStaSet | output | UNC_W | Uncorrectable status set pulses |
| logReq | output | 1 | Request to record the error header |
| msgValid | output | 1 | Error message strobe |
| msgSev | output | 2 | Message severity code |

## Verification
The bench builds the block with 8-bit correctable and uncorrectable registers and puts the advisory bit at position 5. It leaves bit 7 unsupported for the correctable class and bit 6 unsupported for the uncorrectable class. At that size every single-bit status, the zero vector, a two-bit vector and a vector that becomes one-hot only after masking can all be applied against every combination of the five enables and the class, advisory and unsupported-request flags. The masks and severity words are complementary patterns, so each status bit is seen both masked and unmasked and both fatal and non-fatal.

// File: rtl/errgate_pkg.sv
package errgate_pkg;

  typedef enum logic [1:0] {
    SEV_COR   = 2'd0,
    SEV_NFAT  = 2'd1,
    SEV_FATAL = 2'd2
  } sev_e;

  localparam int DEV_CED = 0;
  localparam int DEV_NFD = 1;
  localparam int DEV_FED = 2;
  localparam int DEV_URD = 3;
  localparam int DEV_W   = 4;

  // flags the datapath derives from the raw inputs
  typedef struct packed {
    logic ok;          // status one-hot after supported masking
    logic fatal;       // severity bit set at the error position
    logic corMasked;   // correctable bit masked
    logic advMasked;   // advisory bit masked in correctable mask
    logic uncMasked;   // uncorrectable bit masked
  } dpFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setCed;
    logic setNfd;
    logic setFed;
    logic setUrd;
    logic setCor;
    logic setAdv;
    logic setUnc;
    logic logRec;
    logic msg;
    sev_e sev;
  } ctrlStrobes_t;

endpackage

// File: rtl/errgate_dp.sv
module errgate_dp
  import errgate_pkg::*;
#(
  parameter int COR_W = 16,
  parameter int UNC_W = 32,
  parameter logic [COR_W-1:0] COR_SUP = '1,
  parameter logic [UNC_W-1:0] UNC_SUP = '1,
  parameter int ADV_BIT = 13,
  localparam int ERR_W = (COR_W > UNC_W) ? COR_W : UNC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ERR_W-1:0]   errStatus,
  input  logic               errIsCor,
  input  logic [COR_W-1:0]   corMask,
  input  logic [UNC_W-1:0]   uncMask,
  input  logic [UNC_W-1:0]   uncSeverity,
  input  ctrlStrobes_t       ctrl,
  output dpFlags_t           flags,
  output logic [DEV_W-1:0]   devStaSet,
  output logic [COR_W-1:0]   corStaSet,
  output logic [UNC_W-1:0]   uncStaSet,
  output logic               logReq,
  output logic               msgValid,
  output logic [1:0]         msgSev
);

  logic [COR_W-1:0] corSel;
  logic [UNC_W-1:0] uncSel;
  logic [COR_W-1:0] advVec;
  logic             corOk;
  logic             uncOk;

  assign corSel = errStatus[COR_W-1:0] & COR_SUP;
  assign uncSel = errStatus[UNC_W-1:0] & UNC_SUP;

  for (genvar i = 0; i < COR_W; i++) begin : g_adv
    assign advVec[i] = (i == ADV_BIT);
  end

  assign corOk = (corSel != '0) && ((corSel & (corSel - 1'b1)) == '0);
  assign uncOk = (uncSel != '0) && ((uncSel & (uncSel - 1'b1)) == '0);

  always_comb begin
    flags.ok        = errIsCor ? corOk : uncOk;
    flags.fatal     = |(uncSel & uncSeverity);
    flags.corMasked = |(corSel & corMask);
    flags.advMasked = |(advVec & corMask);
    flags.uncMasked = |(uncSel & uncMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devStaSet <= '0;
      corStaSet <= '0;
      uncStaSet <= '0;
      logReq    <= 1'b0;
      msgValid  <= 1'b0;
      msgSev    <= '0;
    end else begin
      devStaSet[DEV_CED] <= ctrl.setCed;
      devStaSet[DEV_NFD] <= ctrl.setNfd;
      devStaSet[DEV_FED] <= ctrl.setFed;
      devStaSet[DEV_URD] <= ctrl.setUrd;
      corStaSet <= ctrl.setCor ? corSel : (ctrl.setAdv ? advVec : '0);
      uncStaSet <= ctrl.setUnc ? uncSel : '0;
      logReq    <= ctrl.logRec;
      msgValid  <= ctrl.msg;
      msgSev    <= ctrl.msg ? ctrl.sev : SEV_COR;
    end
  end

endmodule

// File: rtl/errgate_ctrl.sv
module errgate_ctrl
  import errgate_pkg::*;
(
  input  logic         errValid,
  input  logic         errIsCor,
  input  logic         errMayAdvisory,
  input  logic         errIsUr,
  input  logic         corRptEn,
  input  logic         nfRptEn,
  input  logic         fatRptEn,
  input  logic         urRptEn,
  input  logic         serrEn,
  input  dpFlags_t     flags,
  output ctrlStrobes_t ctrl
);

  logic go;
  logic advPath;
  logic corLike;
  logic corBitMasked;
  logic corMsgOk;
  logic uncMsgOk;
  logic urBlocked;

  assign go           = errValid && flags.ok;
  assign advPath      = !errIsCor && !flags.fatal && errMayAdvisory;
  assign corLike      = errIsCor || advPath;
  assign corBitMasked = errIsCor ? flags.corMasked : flags.advMasked;

  // correctable-style reporting: mask, enable, optional UR enable
  assign corMsgOk = !corBitMasked && corRptEn && (!errIsUr || urRptEn);

  // uncorrectable reporting: mask, UR gate, then per-severity enable
  assign urBlocked = errIsUr && !urRptEn && !serrEn;
  assign uncMsgOk  = !flags.uncMasked && !urBlocked &&
                     (flags.fatal ? (serrEn || fatRptEn) : (serrEn || nfRptEn));

  always_comb begin
    ctrl.setCed = go && corLike;
    ctrl.setNfd = go && !corLike && !flags.fatal;
    ctrl.setFed = go && !corLike && flags.fatal;
    ctrl.setUrd = go && errIsUr;
    ctrl.setCor = go && errIsCor;
    ctrl.setAdv = go && advPath;
    ctrl.setUnc = go && !errIsCor;
    ctrl.logRec = go && !errIsCor && !flags.uncMasked &&
                  (!advPath || !flags.advMasked);
    ctrl.msg    = go && (corLike ? corMsgOk : uncMsgOk);
    if (corLike)          ctrl.sev = SEV_COR;
    else if (flags.fatal) ctrl.sev = SEV_FATAL;
    else                  ctrl.sev = SEV_NFAT;
  end

endmodule

// File: rtl/errgate_top.sv
module errgate_top
  import errgate_pkg::*;
#(
  parameter int COR_W = 16,
  parameter int UNC_W = 32,
  parameter logic [COR_W-1:0] COR_SUP = '1,
  parameter logic [UNC_W-1:0] UNC_SUP = '1,
  parameter int ADV_BIT = 13,
  localparam int ERR_W = (COR_W > UNC_W) ? COR_W : UNC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errValid,
  input  logic [ERR_W-1:0] errStatus,
  input  logic             errIsCor,
  input  logic             errMayAdvisory,
  input  logic             errIsUr,
  input  logic             corRptEn,
  input  logic             nfRptEn,
  input  logic             fatRptEn,
  input  logic             urRptEn,
  input  logic             serrEn,
  input  logic [COR_W-1:0] corMask,
  input  logic [UNC_W-1:0] uncMask,
  input  logic [UNC_W-1:0] uncSeverity,
  output logic [3:0]       devStaSet,
  output logic [COR_W-1:0] corStaSet,
  output logic [UNC_W-1:0] uncStaSet,
  output logic             logReq,
  output logic             msgValid,
  output logic [1:0]       msgSev
);

  dpFlags_t     flags;
  ctrlStrobes_t ctrl;

  errgate_ctrl ctrl_i (
    .errValid      (errValid),
    .errIsCor      (errIsCor),
    .errMayAdvisory(errMayAdvisory),
    .errIsUr       (errIsUr),
    .corRptEn      (corRptEn),
    .nfRptEn       (nfRptEn),
    .fatRptEn      (fatRptEn),
    .urRptEn       (urRptEn),
    .serrEn        (serrEn),
    .flags         (flags),
    .ctrl          (ctrl)
  );

  errgate_dp #(
    .COR_W  (COR_W),
    .UNC_W  (UNC_W),
    .COR_SUP(COR_SUP),
    .UNC_SUP(UNC_SUP),
    .ADV_BIT(ADV_BIT)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .errStatus  (errStatus),
    .errIsCor   (errIsCor),
    .corMask    (corMask),
    .uncMask    (uncMask),
    .uncSeverity(uncSeverity),
    .ctrl       (ctrl),
    .flags      (flags),
    .devStaSet  (devStaSet),
    .corStaSet  (corStaSet),
    .uncStaSet  (uncStaSet),
    .logReq     (logReq),
    .msgValid   (msgValid),
    .msgSev     (msgSev)
  );

endmodule

// File: rtl/errgate_chk.sv
module errgate_chk #(
  parameter int COR_W = 16,
  parameter int UNC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             errValid,
  input logic [3:0]       devStaSet,
  input logic [COR_W-1:0] corStaSet,
  input logic [UNC_W-1:0] uncStaSet,
  input logic             logReq,
  input logic             msgValid,
  input logic [1:0]       msgSev
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(errValid)) |-> (devStaSet == '0 && !logReq && !msgValid));

  assert_sev_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgSev != 2'd3));

  assert_cor_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(corStaSet));

  assert_unc_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(uncStaSet));

  assert_cor_msg_ced_R4: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgSev == 2'd0) |-> devStaSet[0]);

  assert_class_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(devStaSet[1] && devStaSet[2]));

  assert_log_needs_unc_R9: assert property (@(posedge clk) disable iff (!rstN)
    logReq |-> (uncStaSet != '0));

  assert_fatal_msg_fed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgSev == 2'd2) |-> devStaSet[2]);

endmodule

bind errgate_top errgate_chk #(.COR_W(COR_W), .UNC_W(UNC_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .errValid (errValid),
  .devStaSet(devStaSet),
  .corStaSet(corStaSet),
  .uncStaSet(uncStaSet),
  .logReq   (logReq),
  .msgValid (msgValid),
  .msgSev   (msgSev)
);

// File: tb/errgate_top_tb_top.sv
`timescale 1ns/1ps
module errgate_top_tb_top;

  localparam int W = 8;
  localparam logic [W-1:0] CSUP = 8'h7F;
  localparam logic [W-1:0] USUP = 8'hBF;
  localparam int ADV = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errValid = 1'b0;
  logic [W-1:0] errStatus = '0;
  logic errIsCor = 1'b0, errMayAdvisory = 1'b0, errIsUr = 1'b0;
  logic corRptEn = 1'b0, nfRptEn = 1'b0, fatRptEn = 1'b0, urRptEn = 1'b0, serrEn = 1'b0;
  logic [W-1:0] corMask = '0, uncMask = '0, uncSeverity = '0;
  logic [3:0] devStaSet;
  logic [W-1:0] corStaSet, uncStaSet;
  logic logReq, msgValid;
  logic [1:0] msgSev;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  errgate_top #(
    .COR_W(W), .UNC_W(W), .COR_SUP(CSUP), .UNC_SUP(USUP), .ADV_BIT(ADV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errStatus(errStatus),
    .errIsCor(errIsCor), .errMayAdvisory(errMayAdvisory), .errIsUr(errIsUr),
    .corRptEn(corRptEn), .nfRptEn(nfRptEn), .fatRptEn(fatRptEn),
    .urRptEn(urRptEn), .serrEn(serrEn), .corMask(corMask), .uncMask(uncMask),
    .uncSeverity(uncSeverity), .devStaSet(devStaSet), .corStaSet(corStaSet),
    .uncStaSet(uncStaSet), .logReq(logReq), .msgValid(msgValid), .msgSev(msgSev)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit oneHot(input logic [W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  function automatic logic [W-1:0] pattern(input int i);
    if (i == 0) return '0;
    if (i <= 8) return 8'(1 << (i - 1));
    if (i == 9) return 8'h41;
    return 8'h03;
  endfunction

  task automatic checkQuiet(input string req);
    check(req, "dev", 32'(devStaSet), 0);
    check(req, "cor", 32'(corStaSet), 0);
    check(req, "unc", 32'(uncStaSet), 0);
    check(req, "log", 32'(logReq), 0);
    check(req, "msg", 32'(msgValid), 0);
  endtask

  task automatic applyOne();
    logic [W-1:0] cSel, uSel, sel;
    logic [3:0] eDev;
    logic [W-1:0] eCor, eUnc;
    logic eLog, eMsg, fat, adv, corLike, ok, bitMasked;
    logic [1:0] eSev;
    string tagSt, tagMsg;

    cSel = errStatus & CSUP;
    uSel = errStatus & USUP;
    sel = errIsCor ? cSel : uSel;
    ok = oneHot(sel);
    fat = |(uSel & uncSeverity);
    adv = !errIsCor && !fat && errMayAdvisory;
    corLike = errIsCor || adv;
    eDev = '0; eCor = '0; eUnc = '0; eLog = 0; eMsg = 0; eSev = 0;
    tagSt = "R2"; tagMsg = "R2";
    if (ok) begin
      eDev[3] = errIsUr;
      if (corLike) begin
        eDev[0] = 1'b1;                                   // R3 / R6
        eCor = errIsCor ? cSel : 8'(1 << ADV);
        bitMasked = errIsCor ? |(cSel & corMask) : corMask[ADV];
        eMsg = !bitMasked && corRptEn && (!errIsUr || urRptEn);  // R4
        eSev = 2'd0;
        tagMsg = "R4";
      end else begin
        eDev[1] = !fat;                                   // R5
        eDev[2] = fat;
        eMsg = !(|(uSel & uncMask)) && !(errIsUr && !urRptEn && !serrEn) &&
               (fat ? (serrEn || fatRptEn) : (serrEn || nfRptEn)); // R10
        eSev = fat ? 2'd2 : 2'd1;
        tagMsg = "R10";
      end
      if (!errIsCor) begin
        eUnc = uSel;
        eLog = !(|(uSel & uncMask)) && (!adv || !corMask[ADV]);  // R7 / R8 / R9
      end
      if (errIsCor) tagSt = "R3";
      else if (adv) tagSt = "R7";
      else if (|(uSel & uncMask)) tagSt = "R8";
      else tagSt = "R9";
    end
    errValid = 1'b1;
    @(negedge clk);
    errValid = 1'b0;
    check(tagSt, "devStaSet", 32'(devStaSet), 32'(eDev));
    check(adv ? "R6" : tagSt, "corStaSet", 32'(corStaSet), 32'(eCor));
    check(tagSt, "uncStaSet", 32'(uncStaSet), 32'(eUnc));
    check(tagSt, "logReq", 32'(logReq), 32'(eLog));
    check(tagMsg, "msgValid", 32'(msgValid), 32'(eMsg));
    if (eMsg) check("R5", "msgSev", 32'(msgSev), 32'(eSev));
    @(negedge clk);
    checkQuiet("R1");
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkQuiet("R1");
    for (int p = 0; p < 11; p++) begin
      for (int f = 0; f < 8; f++) begin
        for (int en = 0; en < 32; en++) begin
          for (int m = 0; m < 8; m++) begin
            errStatus      = pattern(p);
            errIsCor       = f[0];
            errMayAdvisory = f[1];
            errIsUr        = f[2];
            corRptEn       = en[0];
            nfRptEn        = en[1];
            fatRptEn       = en[2];
            urRptEn        = en[3];
            serrEn         = en[4];
            corMask        = m[0] ? 8'h2C : 8'hD3;
            uncMask        = m[1] ? 8'h96 : 8'h69;
            uncSeverity    = m[2] ? 8'hAA : 8'h55;
            applyOne();
          end
        end
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule